// File: doc/BRIEF.md
# Single-Wire Slave Memory Function Handler

This block is the byte-level function layer of a slave on a single-wire bus. A bit-slot engine, which is not part of this block, gives it each received byte with a valid strobe. It also marks bus reset pulses and asks for every bit the slave has to drive during a read slot. The handler takes a function opcode and a one-byte target address. It then either streams a 256-byte register space out bit by bit, or writes the incoming bytes into that space, or sends a single copy, recall or lock strobe to a shadowed nonvolatile array that is organised in blocks.

A read runs without a break. The least significant bit of each byte goes out first, and the first bit of the next address follows straight after the last bit of the current one. Once the read has passed the top address, every bit is a one. A write advances the address after every byte. A byte aimed at a protected block is dropped silently, and a byte that would go past the top address is dropped as well. A bus reset pulse ends whatever is in progress at any bit and makes the handler ready for a new opcode.

Top module: `sw_mem_handler`

## Requirements
- R1: After `rstN` is released or after a `busReset` pulse, `txBit` is 1, `memWrEn` is 0 and none of `nvCopy`, `nvRecall`, `nvLock` is asserted.
- R2: Opcode 0x69 followed by address byte A starts a read. The bit offered on `txBit` then comes from byte A, least significant bit first, and each `txReq` pulse moves on to the next bit.
- R3: In a read, bit 0 of address A+1 follows directly after bit 7 of address A, so a read crosses byte boundaries without a gap.
- R4: Once bit 7 of address 0xFF has been taken, every following read bit is 1 until `busReset`.
- R5: Opcode 0x6C followed by address byte A starts a write. Each following byte is written to A, A+1, A+2 and so on, with one `memWrEn` cycle per byte.
- R6: A write byte whose address has `memWrProt` high is dropped with no `memWrEn`. The address still advances, so the next byte goes to the next address.
- R7: After the byte for address 0xFF has been handled, further write bytes are dropped until `busReset`.
- R8: Opcode 0x48 followed by address A gives one cycle of `nvCopy`, with `nvBlock` equal to A shifted right by 4 (16-byte blocks).
- R9: Opcode 0xB8 followed by address A gives one cycle of `nvRecall`, with `nvBlock` equal to A shifted right by 4.
- R10: Opcode 0x6A followed by address A gives one cycle of `nvLock`, with `nvBlock` equal to A shifted right by 4.
- R11: After a copy, recall or lock strobe, received bytes cause no write and no further strobe, and `txBit` stays 1, until `busReset`.
- R12: An opcode that is not one of 0x69, 0x6C, 0x48, 0xB8 or 0x6A makes the handler ignore all bytes and read requests until `busReset`. During that time `txBit` reads 1.
- R13: A `busReset` pulse in the middle of a read or a write, at any bit, ends the transfer. The next byte received is decoded as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | 8 | Byte received from the bit-slot engine |
| rxValid | input | 1 | One-cycle strobe: rxByte is valid |
| busReset | input | 1 | One-cycle strobe: a bus reset pulse was seen |
| txReq | input | 1 | One-cycle strobe: the current txBit has been sent |
| txBit | output | 1 | Bit to drive in the next read slot (1 when released) |
| memAddr | output | ADDR_W | Current register-space address |
| memRdData | input | 8 | Combinational read data at memAddr |
| memWrEn | output | 1 | Write memWrData to memAddr on this edge |
| memWrData | output | 8 | Write data |
| memWrProt | input | 1 | The block holding memAddr is locked or read-only |
| nvCopy | output | 1 | Copy strobe: shadow block to nonvolatile |
| nvRecall | output | 1 | Recall strobe: nonvolatile block to shadow |
| nvLock | output | 1 | Lock strobe for a nonvolatile block |
| nvBlock | output | ADDR_W-BLK_LOG2 | Block index for the strobes |

## Verification
The hardest case to reach from the ports is the move past the top address. It only happens after the handler has counted out every bit of address 0xFF, and a read that started low in the space would need thousands of slots to get there. The stimulus therefore starts reads and writes at 0xFE and 0xFF and keeps requesting bits across the wrap. A bus reset is also sent three bits into a byte and in the middle of a write. The bench then checks that the byte which follows is decoded again as an opcode.

// File: rtl/sw_mem_pkg.sv
package sw_mem_pkg;
  localparam logic [7:0] OP_READ   = 8'h69;
  localparam logic [7:0] OP_WRITE  = 8'h6C;
  localparam logic [7:0] OP_COPY   = 8'h48;
  localparam logic [7:0] OP_RECALL = 8'hB8;
  localparam logic [7:0] OP_LOCK   = 8'h6A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_READ, ST_WRITE, ST_ISSUE, ST_HALT
  } fnState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadAddr;
    logic stepBit;
    logic stepByte;
    logic rdActive;
  } dpCmd_t;
endpackage

// File: rtl/sw_mem_ctrl.sv
module sw_mem_ctrl
  import sw_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       busReset,
  input  logic       txReq,
  input  logic       memWrProt,
  input  logic       addrAtTop,
  output dpCmd_t     cmd,
  output logic       memWrEn,
  output logic       nvCopy,
  output logic       nvRecall,
  output logic       nvLock
);
  fnState_t state, nextState;
  logic [7:0] opcode;
  logic opKnown;

  always_comb begin
    opKnown = (rxByte == OP_READ) || (rxByte == OP_WRITE) || (rxByte == OP_COPY) ||
              (rxByte == OP_RECALL) || (rxByte == OP_LOCK);
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    memWrEn   = 1'b0;
    nvCopy    = 1'b0;
    nvRecall  = 1'b0;
    nvLock    = 1'b0;
    if (busReset) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (rxValid) nextState = opKnown ? ST_ADDR : ST_HALT;
        ST_ADDR: if (rxValid) begin
          cmd.loadAddr = 1'b1;
          if (opcode == OP_READ)       nextState = ST_READ;
          else if (opcode == OP_WRITE) nextState = ST_WRITE;
          else                         nextState = ST_ISSUE;
        end
        ST_READ: begin
          cmd.rdActive = 1'b1;
          cmd.stepBit  = txReq;
        end
        ST_WRITE: if (rxValid) begin
          cmd.stepByte = 1'b1;
          memWrEn      = !memWrProt;
          if (addrAtTop) nextState = ST_HALT;
        end
        ST_ISSUE: begin
          nvCopy    = (opcode == OP_COPY);
          nvRecall  = (opcode == OP_RECALL);
          nvLock    = (opcode == OP_LOCK);
          nextState = ST_HALT;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opcode <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && rxValid && !busReset) opcode <= rxByte;
    end
  end
endmodule

// File: rtl/sw_mem_dp.sv
module sw_mem_dp
  import sw_mem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCmd_t                     cmd,
  input  logic [7:0]                 rxByte,
  input  logic [7:0]                 memRdData,
  output logic                       txBit,
  output logic                       addrAtTop,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [7:0]                 memWrData,
  output logic [ADDR_W-BLK_LOG2-1:0] nvBlock
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addrReg;
  logic [2:0]        bitIdx;
  logic              pastEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      bitIdx  <= '0;
      pastEnd <= 1'b0;
    end else if (cmd.loadAddr) begin
      addrReg <= rxByte[ADDR_W-1:0];
      bitIdx  <= '0;
      pastEnd <= 1'b0;
    end else if (cmd.stepByte) begin
      addrReg <= addrReg + ONE;
    end else if (cmd.stepBit) begin
      bitIdx <= bitIdx + 3'd1;
      if (bitIdx == 3'd7) begin
        addrReg <= addrReg + ONE;
        if (addrReg == TOP_ADDR) pastEnd <= 1'b1;
      end
    end
  end

  assign addrAtTop = (addrReg == TOP_ADDR);
  assign memAddr   = addrReg;
  assign memWrData = rxByte;
  assign nvBlock   = addrReg[ADDR_W-1:BLK_LOG2];
  assign txBit     = cmd.rdActive ? (pastEnd | memRdData[bitIdx]) : 1'b1;
endmodule

// File: rtl/sw_mem_handler.sv
module sw_mem_handler
  import sw_mem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [7:0]                 rxByte,
  input  logic                       rxValid,
  input  logic                       busReset,
  input  logic                       txReq,
  output logic                       txBit,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic [7:0]                 memRdData,
  output logic                       memWrEn,
  output logic [7:0]                 memWrData,
  input  logic                       memWrProt,
  output logic                       nvCopy,
  output logic                       nvRecall,
  output logic                       nvLock,
  output logic [ADDR_W-BLK_LOG2-1:0] nvBlock
);
  dpCmd_t cmd;
  logic   addrAtTop;

  sw_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .busReset(busReset), .txReq(txReq), .memWrProt(memWrProt),
    .addrAtTop(addrAtTop), .cmd(cmd), .memWrEn(memWrEn),
    .nvCopy(nvCopy), .nvRecall(nvRecall), .nvLock(nvLock)
  );

  sw_mem_dp #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxByte(rxByte),
    .memRdData(memRdData), .txBit(txBit), .addrAtTop(addrAtTop),
    .memAddr(memAddr), .memWrData(memWrData), .nvBlock(nvBlock)
  );
endmodule

// File: rtl/sw_mem_chk.sv
module sw_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReset,
  input logic              txBit,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn,
  input logic              nvCopy,
  input logic              nvRecall,
  input logic              nvLock
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (txBit && !memWrEn && !nvCopy && !nvRecall && !nvLock));

  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !busReset) |=> (memAddr == $past(memAddr) + ONE));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nvCopy, nvRecall, nvLock}));

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nvCopy || nvRecall || nvLock) |=> !(nvCopy || nvRecall || nvLock || memWrEn));
endmodule

bind sw_mem_handler sw_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .txBit(txBit),
  .memAddr(memAddr), .memWrEn(memWrEn), .nvCopy(nvCopy),
  .nvRecall(nvRecall), .nvLock(nvLock)
);

// File: tb/sim_sw_mem_handler.sv
`timescale 1ns/1ps
module sim_sw_mem_handler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0, busReset = 1'b0, txReq = 1'b0;
  logic txBit, memWrEn, nvCopy, nvRecall, nvLock;
  logic [7:0] memAddr, memRdData, memWrData;
  logic memWrProt;
  logic [3:0] nvBlock;
  logic [7:0] mem [256];
  int wrCount = 0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sw_mem_handler u0 (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .busReset(busReset), .txReq(txReq), .txBit(txBit), .memAddr(memAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .memWrProt(memWrProt), .nvCopy(nvCopy), .nvRecall(nvRecall),
    .nvLock(nvLock), .nvBlock(nvBlock)
  );

  // block 2 (0x20..0x2F) is protected
  assign memWrProt = (memAddr[7:4] == 4'h2);
  assign memRdData = mem[memAddr];

  always @(posedge clk) if (memWrEn) begin
    mem[memAddr] <= memWrData;
    wrCount <= wrCount + 1;
  end

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b);
    rxByte = b; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic pulseReset();
    busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic getByte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      #1 b[i] = txBit;
      txReq = 1'b1;
      @(negedge clk); txReq = 1'b0;
    end
  endtask

  task automatic testReset();
    check("R1 txBit", txBit, 1);
    check("R1 strobes", {memWrEn, nvCopy, nvRecall, nvLock}, 0);
  endtask

  task automatic testRead();
    logic [7:0] b;
    pulseReset(); sendByte(8'h69); sendByte(8'h10);
    for (int k = 0; k < 3; k++) begin
      getByte(b);
      check(k == 0 ? "R2 first byte" : "R3 next byte", b, initVal(16 + k));
    end
  endtask

  task automatic testReadTop();
    logic [7:0] b;
    pulseReset(); sendByte(8'h69); sendByte(8'hFE);
    getByte(b); check("R3 byte FE", b, initVal(254));
    getByte(b); check("R3 byte FF", b, initVal(255));
    getByte(b); check("R4 past top", b, 8'hFF);
    getByte(b); check("R4 past top again", b, 8'hFF);
  endtask

  task automatic testWrite();
    int w0;
    pulseReset(); sendByte(8'h6C); sendByte(8'h40);
    w0 = wrCount;
    sendByte(8'hAA); sendByte(8'h55); sendByte(8'hC3);
    check("R5 wr count", wrCount - w0, 3);
    check("R5 data", {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'hAA55C3);
  endtask

  task automatic testProtect();
    int w0;
    pulseReset(); sendByte(8'h6C); sendByte(8'h2F);
    w0 = wrCount;
    sendByte(8'h11); sendByte(8'h22);
    check("R6 protected kept", mem[8'h2F], initVal(47));
    check("R6 next written", mem[8'h30], 8'h22);
    check("R6 wr count", wrCount - w0, 1);
  endtask

  task automatic testWriteTop();
    pulseReset(); sendByte(8'h6C); sendByte(8'hFF);
    sendByte(8'h77); sendByte(8'h88);
    check("R7 FF written", mem[8'hFF], 8'h77);
    check("R7 no wrap", mem[8'h00], initVal(0));
  endtask

  task automatic testStrobe(string req, logic [7:0] op, logic [7:0] a, logic [2:0] expVec);
    int w0;
    pulseReset(); sendByte(op); sendByte(a);
    #1 check(req, {nvCopy, nvRecall, nvLock}, expVec);
    check({req, " block"}, nvBlock, a[7:4]);
    @(negedge clk);
    #1 check({req, " one cycle"}, {nvCopy, nvRecall, nvLock}, 0);
    w0 = wrCount;
    sendByte(8'h6C); sendByte(8'h01); sendByte(8'h99);
    #1 check("R11 ignored writes", wrCount - w0, 0);
    check("R11 no strobe", {nvCopy, nvRecall, nvLock}, 0);
    check("R11 txBit", txBit, 1);
  endtask

  task automatic testUnknown();
    int w0;
    logic [7:0] b;
    pulseReset(); w0 = wrCount;
    sendByte(8'h33); sendByte(8'h6C); sendByte(8'h50); sendByte(8'h12);
    check("R12 no write", wrCount - w0, 0);
    check("R12 mem kept", mem[8'h50], initVal(80));
    getByte(b); check("R12 read ones", b, 8'hFF);
  endtask

  task automatic testAbort();
    logic [7:0] b;
    int w0;
    pulseReset(); sendByte(8'h69); sendByte(8'h10);
    for (int i = 0; i < 3; i++) begin
      txReq = 1'b1; @(negedge clk); txReq = 1'b0;
    end
    pulseReset();
    #1 check("R13 released", txBit, 1);
    sendByte(8'h69); sendByte(8'h20);
    getByte(b); check("R13 new read", b, initVal(32));
    pulseReset(); sendByte(8'h6C); sendByte(8'h60);
    pulseReset(); w0 = wrCount;
    sendByte(8'h44); sendByte(8'h55);
    check("R13 write aborted", wrCount - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = initVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1 testReset();
    testRead();
    testReadTop();
    testWrite();
    testProtect();
    testWriteTop();
    testStrobe("R8 copy", 8'h48, 8'h37, 3'b100);
    testStrobe("R9 recall", 8'hB8, 8'hA5, 3'b010);
    testStrobe("R10 lock", 8'h6A, 8'h01, 3'b001);
    testUnknown();
    testAbort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule